// File: doc/BRIEF.md
# Bitwise Universal Hash Generator

This block turns one input word (a window of string bytes) into several independent table addresses at once. Every hash function owns one constant per input bit. A hash value starts at zero. Each input bit that is set folds that bit's constant into the value by XOR, and each bit that is clear leaves the value alone. All hash functions see the same word in the same cycle, so a lookup stage that needs several random addresses per word gets them together.

The constants are written one at a time through a small configuration port during setup. Which values to pick is up to the software that fills the table. The fold runs from bit 0 upward, so the value over a short leading part of the word is an intermediate result of the full value. The block brings out the hash over the first `PREFIX_BITS` bits next to the hash over the whole word. A lookup for shorter strings can therefore reuse the same logic. Both results are registered with one cycle of latency, and a valid flag travels alongside them.

Top module: `hash_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `outValid` goes to 0, both hash outputs go to all zeros, and every stored constant is cleared. A word hashed after reset and before any constant write therefore gives 0 for every hash.
- R2: `outValid` after a clock edge equals the `inValid` sampled at that edge.
- R3: When `inValid` is high at an edge, slice h of `hashFull` (bits `h*ADDR_W` upward) becomes the XOR of the constants d(h,j) over every bit j of `inWord` that is 1, for j from 0 to `IN_BITS-1`.
- R4: Under the same condition, slice h of `hashPrefix` becomes the same XOR taken only over bits 0 to `PREFIX_BITS-1`.
- R5: If the bits of a captured word at `PREFIX_BITS` and above are all 0, the full hash equals the prefix hash for every hash function.
- R6: A captured all-zero word yields 0 on every slice of both outputs.
- R7: While `inValid` is low at an edge, both hash outputs keep their previous values.
- R8: When `cfgWe` is high at an edge, `cfgData` is stored as d(`cfgHash`,`cfgBit`). A word captured at that same edge still uses the old constant. Words captured from the next edge on use the new one.
- R9: A constant write for one hash function changes no other hash function's result.
- R10: A word with only bit j set returns exactly d(h,j) on slice h of `hashFull`. On `hashPrefix` it returns d(h,j) when j < `PREFIX_BITS` and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word is valid this cycle |
| inWord | input | IN_BITS (32) | Word to hash, bit 0 folded first |
| cfgWe | input | 1 | Constant write strobe |
| cfgHash | input | HASH_IDX_W (2) | Hash function selected for the write |
| cfgBit | input | BIT_IDX_W (5) | Input bit selected for the write |
| cfgData | input | ADDR_W (8) | Constant value to store |
| outValid | output | 1 | Hash outputs hold a new result |
| hashFull | output | NUM_HASH*ADDR_W (32) | Hashes over the whole word, hash 0 in the low slice |
| hashPrefix | output | NUM_HASH*ADDR_W (32) | Hashes over the first PREFIX_BITS bits |

## Verification
A constant stored in the wrong slot, or a broken link in the XOR chain, shows up on the very next captured word whose set bits touch that slot. Walking a single set bit through every position exposes each constant on its own slice one cycle later. A fault in the upper part of the chain moves `hashFull` while `hashPrefix` stays correct, so comparing the two outputs narrows the fault to one side of the prefix boundary. A wrong capture or valid stage shows up as a result that lands one cycle off, or as an output that changes while `inValid` is low.

// File: rtl/hash_gen_pkg.sv
package hash_gen_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // register new hash results
    logic load;     // store one constant
  } hgStrobe_t;
endpackage

// File: rtl/hash_gen_ctrl.sv
module hash_gen_ctrl
  import hash_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      cfgWe,
  output hgStrobe_t strobe,
  output logic      outValid
);
  always_comb begin
    strobe.capture = inValid;
    strobe.load    = cfgWe;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/hash_gen_dp.sv
module hash_gen_dp
  import hash_gen_pkg::*;
#(
  parameter int IN_BITS     = 32,
  parameter int ADDR_W      = 8,
  parameter int NUM_HASH    = 4,
  parameter int PREFIX_BITS = 16,
  parameter int HASH_IDX_W  = 2,
  parameter int BIT_IDX_W   = 5
)(
  input  logic                       clk,
  input  logic                       rst,
  input  hgStrobe_t                  strobe,
  input  logic [IN_BITS-1:0]         inWord,
  input  logic [HASH_IDX_W-1:0]      cfgHash,
  input  logic [BIT_IDX_W-1:0]       cfgBit,
  input  logic [ADDR_W-1:0]          cfgData,
  output logic [NUM_HASH*ADDR_W-1:0] hashFull,
  output logic [NUM_HASH*ADDR_W-1:0] hashPrefix
);
  logic [ADDR_W-1:0] constTab [NUM_HASH][IN_BITS];
  logic [ADDR_W-1:0] partial  [NUM_HASH][IN_BITS+1];
  logic [ADDR_W-1:0] fullQ    [NUM_HASH];
  logic [ADDR_W-1:0] prefixQ  [NUM_HASH];

  for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
    // constant storage, one register per (hash, bit)
    for (genvar b = 0; b < IN_BITS; b++) begin : g_const
      always_ff @(posedge clk) begin
        if (rst)
          constTab[h][b] <= '0;
        else if (strobe.load && cfgHash == HASH_IDX_W'(h) && cfgBit == BIT_IDX_W'(b))
          constTab[h][b] <= cfgData;
      end
    end

    // cumulative fold: each stage adds one bit's contribution
    assign partial[h][0] = '0;
    for (genvar b = 0; b < IN_BITS; b++) begin : g_chain
      assign partial[h][b+1] = partial[h][b] ^ (constTab[h][b] & {ADDR_W{inWord[b]}});
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        fullQ[h]   <= '0;
        prefixQ[h] <= '0;
      end else if (strobe.capture) begin
        fullQ[h]   <= partial[h][IN_BITS];
        prefixQ[h] <= partial[h][PREFIX_BITS];
      end
    end

    assign hashFull[h*ADDR_W +: ADDR_W]   = fullQ[h];
    assign hashPrefix[h*ADDR_W +: ADDR_W] = prefixQ[h];
  end
endmodule

// File: rtl/hash_gen.sv
module hash_gen
  import hash_gen_pkg::*;
#(
  parameter int IN_BITS       = 32,
  parameter int ADDR_W        = 8,
  parameter int NUM_HASH      = 4,
  parameter int PREFIX_BITS   = 16,
  localparam int HASH_IDX_W   = (NUM_HASH > 1) ? $clog2(NUM_HASH) : 1,
  localparam int BIT_IDX_W    = (IN_BITS > 1) ? $clog2(IN_BITS) : 1,
  localparam int OUT_W        = NUM_HASH * ADDR_W
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [IN_BITS-1:0]    inWord,
  input  logic                  cfgWe,
  input  logic [HASH_IDX_W-1:0] cfgHash,
  input  logic [BIT_IDX_W-1:0]  cfgBit,
  input  logic [ADDR_W-1:0]     cfgData,
  output logic                  outValid,
  output logic [OUT_W-1:0]      hashFull,
  output logic [OUT_W-1:0]      hashPrefix
);
  hgStrobe_t strobe;

  hash_gen_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .cfgWe    (cfgWe),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hash_gen_dp #(
    .IN_BITS     (IN_BITS),
    .ADDR_W      (ADDR_W),
    .NUM_HASH    (NUM_HASH),
    .PREFIX_BITS (PREFIX_BITS),
    .HASH_IDX_W  (HASH_IDX_W),
    .BIT_IDX_W   (BIT_IDX_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .inWord     (inWord),
    .cfgHash    (cfgHash),
    .cfgBit     (cfgBit),
    .cfgData    (cfgData),
    .hashFull   (hashFull),
    .hashPrefix (hashPrefix)
  );
endmodule

// File: rtl/hash_gen_chk.sv
module hash_gen_chk #(
  parameter int IN_BITS     = 32,
  parameter int PREFIX_BITS = 16,
  parameter int OUT_W       = 32
)(
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [IN_BITS-1:0] inWord,
  input logic               outValid,
  input logic [OUT_W-1:0]   hashFull,
  input logic [OUT_W-1:0]   hashPrefix
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && hashFull == '0 && hashPrefix == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && (inWord >> PREFIX_BITS) == '0) |=> hashFull == hashPrefix);

  assert_zero_word_R6: assert property (@(posedge clk) disable iff (rst)
    (inValid && inWord == '0) |=> (hashFull == '0 && hashPrefix == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(hashFull) && $stable(hashPrefix)));
endmodule

bind hash_gen hash_gen_chk #(
  .IN_BITS     (IN_BITS),
  .PREFIX_BITS (PREFIX_BITS),
  .OUT_W       (OUT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inWord     (inWord),
  .outValid   (outValid),
  .hashFull   (hashFull),
  .hashPrefix (hashPrefix)
);

// File: tb/tb_hash_gen.sv
module tb_hash_gen;
  localparam int IN_BITS = 32;
  localparam int ADDR_W  = 8;
  localparam int NUM_H   = 4;
  localparam int PRE     = 16;

  logic clk = 1'b0;
  logic rst;
  logic inValid;
  logic [IN_BITS-1:0] inWord;
  logic cfgWe;
  logic [1:0] cfgHash;
  logic [4:0] cfgBit;
  logic [ADDR_W-1:0] cfgData;
  logic outValid;
  logic [NUM_H*ADDR_W-1:0] hashFull, hashPrefix;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] consts [NUM_H][IN_BITS];

  always #4 clk = ~clk;

  hash_gen dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .cfgWe(cfgWe), .cfgHash(cfgHash), .cfgBit(cfgBit), .cfgData(cfgData),
    .outValid(outValid), .hashFull(hashFull), .hashPrefix(hashPrefix)
  );

  function automatic logic [ADDR_W-1:0] expHash(int h, logic [IN_BITS-1:0] w, int nb);
    logic [ADDR_W-1:0] acc = '0;
    for (int j = 0; j < nb; j++) if (w[j]) acc ^= consts[h][j];
    return acc;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one word, check all slices one cycle later
  task automatic hashWord(logic [IN_BITS-1:0] w, string req);
    logic [NUM_H*ADDR_W-1:0] ef, ep;
    @(negedge clk);
    inValid = 1'b1; inWord = w;
    @(posedge clk); #2;
    for (int h = 0; h < NUM_H; h++) begin
      ef[h*ADDR_W +: ADDR_W] = expHash(h, w, IN_BITS);
      ep[h*ADDR_W +: ADDR_W] = expHash(h, w, PRE);
    end
    check({req, " full"}, 64'(hashFull), 64'(ef));
    check({req, " prefix"}, 64'(hashPrefix), 64'(ep));
    check("R2 valid", 64'(outValid), 64'd1);
    @(negedge clk); inValid = 1'b0;
  endtask

  task automatic writeConst(int h, int b, logic [ADDR_W-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgHash = 2'(h); cfgBit = 5'(b); cfgData = d;
    @(posedge clk); #1;
    cfgWe = 1'b0;
    consts[h][b] = d;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [IN_BITS-1:0] lcg;
    logic [NUM_H*ADDR_W-1:0] held;
    rst = 1'b1; inValid = 1'b0; inWord = '0; cfgWe = 1'b0;
    cfgHash = '0; cfgBit = '0; cfgData = '0;
    for (int h = 0; h < NUM_H; h++)
      for (int b = 0; b < IN_BITS; b++) consts[h][b] = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 outValid", 64'(outValid), 64'd0);
    check("R1 hashFull", 64'(hashFull), 64'd0);
    check("R1 hashPrefix", 64'(hashPrefix), 64'd0);
    @(negedge clk); rst = 1'b0;
    hashWord('1, "R1 cleared constants");

    // load computed constants, nonzero
    for (int h = 0; h < NUM_H; h++)
      for (int b = 0; b < IN_BITS; b++)
        writeConst(h, b, ADDR_W'((h * 61 + b * 29 + 17) % 255 + 1));

    // R10 walking single bit
    for (int j = 0; j < IN_BITS; j++) hashWord(IN_BITS'(1) << j, "R10 single bit");

    // R6 zero word
    hashWord('0, "R6 zero word");
    // R5 upper half zero
    hashWord(32'h0000_A5C3, "R5 upper zero");
    hashWord(32'h0000_FFFF, "R5 low ones");

    // R3/R4 patterns
    hashWord('1, "R3 all ones");
    hashWord(32'hAAAA_AAAA, "R3 alternating");
    hashWord(32'h5555_5555, "R4 alternating");
    hashWord(32'hFFFF_0000, "R4 upper only");
    lcg = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      hashWord(lcg, "R3 R4 pattern");
    end

    // R7 hold with inValid low while word changes
    held = hashFull;
    @(negedge clk); inValid = 1'b0; inWord = 32'hDEAD_BEEF;
    @(posedge clk); #2;
    check("R7 hold full", 64'(hashFull), 64'(held));
    check("R2 valid low", 64'(outValid), 64'd0);
    @(posedge clk); #2;
    check("R7 hold full 2", 64'(hashFull), 64'(held));

    // R8 write and capture at the same edge: old constant used
    @(negedge clk);
    cfgWe = 1'b1; cfgHash = 2'd2; cfgBit = 5'd3; cfgData = 8'h3C;
    inValid = 1'b1; inWord = 32'h0000_0008;
    @(posedge clk); #2;
    cfgWe = 1'b0;
    check("R8 same edge old", 64'(hashFull[2*ADDR_W +: ADDR_W]), 64'(consts[2][3]));
    consts[2][3] = 8'h3C;
    @(negedge clk); inValid = 1'b0;
    hashWord(32'h0000_0008, "R8 new constant");
    check("R8 new value", 64'(hashFull[2*ADDR_W +: ADDR_W]), 64'h3C);

    // R9 write to hash 1 leaves others alone
    writeConst(1, 20, 8'hC1);
    hashWord(32'h0010_0000, "R9 isolation");
    check("R9 hash0", 64'(hashFull[0 +: ADDR_W]), 64'(consts[0][20]));
    check("R9 hash1", 64'(hashFull[ADDR_W +: ADDR_W]), 64'hC1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule